// File: doc/BRIEF.md
# Controller Operating-State and Sticky Error Register

This block keeps the operating state of a serial controller, namely run versus configuration mode and the master-select bit. It also keeps six sticky error flags: transmit overflow, receive overflow, abort, transmit underflow, receive underflow and mode error. Software never writes these bits directly. Instead it writes a 16-bit command word in which every state bit has one bit that sets it and another that clears it. Any bit left at zero in the command word leaves its state bit untouched, so no read-modify-write is needed.

The serial engine and the FIFOs sit outside this block. Their error events arrive as one-cycle pulses. Each pulse sets its flag only while the matching check-enable input is high.

Leaving run mode follows a small state machine with three states: `MODE_CFG`, `MODE_RUN` and `MODE_DRAIN`. The transitions are:
- `CFG->RUN` happens on a set-enable command.
- `RUN->CFG` happens on a clear-enable command while the engine is idle.
- `RUN->DRAIN` happens on a clear-enable command while the engine is busy.
- `DRAIN->CFG` happens when busy falls.
- `DRAIN->RUN` happens on a set-enable command, which cancels the pending exit.

A single error interrupt request is the OR of all flags, gated by an interrupt enable input.

Top module: `ctl_state_reg`

## Requirements
- R1: While reset is asserted and after it is released, status bits 0 to 12 read zero, the interrupt request is low and the block is in configuration mode.
- R2: A command with bit 1 set (and bit 0 clear) sets status bit 0 (run mode) on the next clock. A command with bit 0 set (and bit 1 clear) clears status bit 0 on the next clock when busy is low.
- R3: A clear-enable command accepted while `busy_in` is high keeps status bit 0 at one until the clock edge at which busy is seen low, after which it reads zero. A set-enable command while this exit is pending keeps the block in run mode.
- R4: Command bit 3 sets and command bit 2 clears the master-select flag, which is shown at status bit 1.
- R5: Each flag has its own command bits and status bit:
  - Transmit overflow is cleared by command bit 8, set by command bit 12 and shown at status bit 8.
  - Receive overflow is cleared by bit 9, set by bit 13 and shown at status bit 9.
  - Abort is cleared by bit 10, set by bit 14 and shown at status bit 10.
  - Transmit underflow is cleared by bit 11, set by bit 15 and shown at status bit 11.
  - Receive underflow is cleared by bit 4, set by bit 5 and shown at status bit 12.
  - Mode error is cleared by bit 6, set by bit 7 and shown at status bit 7.
- R6: The command value 0x0F50 clears all six error flags at once and leaves the enable and master-select bits unchanged.
- R7: When a set bit and its matching clear bit are both one in the same command, that state bit keeps its value. This applies to the enable bit as well.
- R8: An event pulse on `evt_pulse[k]` sets flag k on the next clock only when `err_chk_en[k]` is high. The index order is 0 transmit overflow, 1 receive overflow, 2 abort, 3 transmit underflow, 4 receive underflow.
- R9: A hardware event and a software clear of the same flag in the same cycle leave the flag set.
- R10: `err_irq` is high exactly when `irq_err_en` is high and at least one of the six error flags is set. It follows the flags and the enable without an added register.
- R11: Status bit 13 shows `busy_in` in the same cycle. Bits 14, 15 and 2 to 6 read zero. While `cmd_we` is low, `cmd_word` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word strobe, one cycle per write |
| cmd_word | input | 16 | Paired set/clear command bits |
| evt_pulse | input | 5 | One-cycle hardware error events |
| err_chk_en | input | 5 | Per-event check enables |
| busy_in | input | 1 | Serial engine busy indication |
| irq_err_en | input | 1 | Error interrupt enable |
| status_word | output | 16 | Packed state, flags and busy view |
| run_mode | output | 1 | High outside configuration mode |
| master_sel | output | 1 | Master-select flag |
| err_irq | output | 1 | Error interrupt request |

## Verification
The command decoder is exercised in several ways:
- Each flag is driven by its lone set word and its lone clear word. This separates the bit positions of the six flags and the master bit from one another.
- A combined set-everything word is followed by the clear-all word. This shows that clears spare the enable and master bits.
- Words carrying both halves of a pair tell the "no change" rule apart from either of the one-sided rules.

Hardware events are pulsed once with their check enable low and once with it high. This tells gating apart from passing events straight through, and a same-cycle event plus clear checks that the event takes priority.

The exit from run mode is exercised in three ways:
- It is tried with busy low.
- It is tried with busy held high for several cycles before falling.
- It is tried with a set-enable command arriving mid-drain.

Together these cover every transition of the state machine.

// File: rtl/ctl_state_pkg.sv
package ctl_state_pkg;

    localparam int CMD_W      = 16;
    localparam int STAT_W     = 16;
    localparam int NUM_HW_ERR = 5;
    localparam int NUM_CELLS  = 7;
    localparam int NUM_ERR    = 6;
    localparam int BUSY_POS   = 13;
    localparam int EN_CLR_POS = 0;
    localparam int EN_SET_POS = 1;

    // Cell index order: 0 tx overflow, 1 rx overflow, 2 abort,
    // 3 tx underflow, 4 rx underflow, 5 mode error, 6 master select.
    typedef enum logic [1:0] {
        MODE_CFG   = 2'd0,
        MODE_RUN   = 2'd1,
        MODE_DRAIN = 2'd2
    } mode_e;

    function automatic int cell_clr_pos(input int k);
        case (k)
            0: return 8;
            1: return 9;
            2: return 10;
            3: return 11;
            4: return 4;
            5: return 6;
            default: return 2;
        endcase
    endfunction

    function automatic int cell_set_pos(input int k);
        case (k)
            0: return 12;
            1: return 13;
            2: return 14;
            3: return 15;
            4: return 5;
            5: return 7;
            default: return 3;
        endcase
    endfunction

    function automatic int cell_stat_pos(input int k);
        case (k)
            0: return 8;
            1: return 9;
            2: return 10;
            3: return 11;
            4: return 12;
            5: return 7;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/ctl_cmd_decode.sv
module ctl_cmd_decode
    import ctl_state_pkg::*;
(
    input  logic                 we_i,
    input  logic [CMD_W-1:0]     word_i,
    output logic [NUM_CELLS-1:0] cell_set_o,
    output logic [NUM_CELLS-1:0] cell_clr_o,
    output logic                 en_set_o,
    output logic                 en_clr_o
);

    for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cell
        localparam int SP = cell_set_pos(k);
        localparam int CP = cell_clr_pos(k);
        assign cell_set_o[k] = we_i & word_i[SP];
        assign cell_clr_o[k] = we_i & word_i[CP];
    end

    assign en_set_o = we_i & word_i[EN_SET_POS];
    assign en_clr_o = we_i & word_i[EN_CLR_POS];

endmodule

// File: rtl/ctl_flag_cell.sv
module ctl_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic hw_i,
    output logic q_o
);

    logic q_nxt;

    always_comb begin
        q_nxt = q_o;
        if (hw_i)
            q_nxt = 1'b1;
        else if (set_i && !clr_i)
            q_nxt = 1'b1;
        else if (clr_i && !set_i)
            q_nxt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_o <= 1'b0;
        else
            q_o <= q_nxt;
    end

endmodule

// File: rtl/ctl_mode_fsm.sv
module ctl_mode_fsm
    import ctl_state_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_set_i,
    input  logic en_clr_i,
    input  logic busy_i,
    output logic enable_o
);

    mode_e state_q, state_d;
    logic  go_run, go_cfg;

    assign go_run = en_set_i & ~en_clr_i;
    assign go_cfg = en_clr_i & ~en_set_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= MODE_CFG;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_CFG: begin
                if (go_run)
                    state_d = MODE_RUN;
            end
            MODE_RUN: begin
                if (go_cfg)
                    state_d = busy_i ? MODE_DRAIN : MODE_CFG;
            end
            MODE_DRAIN: begin
                if (go_run)
                    state_d = MODE_RUN;
                else if (!busy_i)
                    state_d = MODE_CFG;
            end
            default: state_d = MODE_CFG;
        endcase
    end

    always_comb begin
        unique case (state_q)
            MODE_CFG:   enable_o = 1'b0;
            MODE_RUN:   enable_o = 1'b1;
            MODE_DRAIN: enable_o = 1'b1;
            default:    enable_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctl_state_reg.sv
module ctl_state_reg
    import ctl_state_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [15:0]       cmd_word,
    input  logic [4:0]        evt_pulse,
    input  logic [4:0]        err_chk_en,
    input  logic              busy_in,
    input  logic              irq_err_en,
    output logic [15:0]       status_word,
    output logic              run_mode,
    output logic              master_sel,
    output logic              err_irq
);

    logic [NUM_CELLS-1:0] cell_set, cell_clr, cell_hw, cell_q;
    logic                 en_set, en_clr, enable;

    ctl_cmd_decode u_dec (
        .we_i       (cmd_we),
        .word_i     (cmd_word),
        .cell_set_o (cell_set),
        .cell_clr_o (cell_clr),
        .en_set_o   (en_set),
        .en_clr_o   (en_clr)
    );

    ctl_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_set_i (en_set),
        .en_clr_i (en_clr),
        .busy_i   (busy_in),
        .enable_o (enable)
    );

    for (genvar k = 0; k < NUM_CELLS; k++) begin : g_cells
        if (k < NUM_HW_ERR) begin : g_hw
            assign cell_hw[k] = evt_pulse[k] & err_chk_en[k];
        end else begin : g_sw
            assign cell_hw[k] = 1'b0;
        end
        ctl_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (cell_set[k]),
            .clr_i (cell_clr[k]),
            .hw_i  (cell_hw[k]),
            .q_o   (cell_q[k])
        );
    end

    always_comb begin
        status_word = '0;
        status_word[0] = enable;
        status_word[BUSY_POS] = busy_in;
        for (int k = 0; k < NUM_CELLS; k++)
            status_word[cell_stat_pos(k)] = cell_q[k];
    end

    assign run_mode   = enable;
    assign master_sel = cell_q[NUM_CELLS-1];
    assign err_irq    = irq_err_en & (|cell_q[NUM_ERR-1:0]);

endmodule

// File: rtl/ctl_state_reg_chk.sv
module ctl_state_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_we,
    input logic [15:0] cmd_word,
    input logic [4:0]  evt_pulse,
    input logic [4:0]  err_chk_en,
    input logic        busy_in,
    input logic        irq_err_en,
    input logic [15:0] status_word,
    input logic        run_mode,
    input logic        master_sel,
    input logic        err_irq
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (status_word[12:0] == 13'd0 && !err_irq));

    // R3
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode && busy_in) |=> run_mode);

    // R7
    pair_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_word[2] && cmd_word[3]) |=> $stable(master_sel));

    // R8
    evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_we && !status_word[9] && evt_pulse[1] && !err_chk_en[1]) |=> !status_word[9]);

    // R9
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse[2] && err_chk_en[2] && cmd_we && cmd_word[10]) |=> status_word[10]);

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_err_en |-> !err_irq);

    // R11
    busy_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[13] == busy_in && status_word[0] == run_mode);

endmodule

bind ctl_state_reg ctl_state_reg_chk chk_i (.*);

// File: tb/ctl_state_reg_tb_top.sv
module ctl_state_reg_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [15:0] cmd_word = '0;
    logic [4:0]  evt_pulse = '0;
    logic [4:0]  err_chk_en = '0;
    logic        busy_in = 1'b0;
    logic        irq_err_en = 1'b0;
    logic [15:0] status_word;
    logic        run_mode, master_sel, err_irq;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    ctl_state_reg dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(cmd_word),
        .evt_pulse(evt_pulse), .err_chk_en(err_chk_en), .busy_in(busy_in),
        .irq_err_en(irq_err_en), .status_word(status_word),
        .run_mode(run_mode), .master_sel(master_sel), .err_irq(err_irq)
    );

    // cell order: txovf, rxovf, abort, txudf, rxudf, moderr, master
    int set_bit  [7] = '{12, 13, 14, 15, 5, 7, 3};
    int clr_bit  [7] = '{8, 9, 10, 11, 4, 6, 2};
    int stat_bit [7] = '{8, 9, 10, 11, 12, 7, 1};

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] w);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_word = w;
        @(negedge clk);
        cmd_we = 1'b0;
        cmd_word = '0;
    endtask

    task automatic t_reset;
        chk("R1 status", status_word, 16'h0000);
        chk("R1 irq", {15'd0, err_irq}, 16'd0);
        chk("R1 run_mode", {15'd0, run_mode}, 16'd0);
    endtask

    task automatic t_enable;
        wr(16'h0002);
        chk("R2 set enable", status_word, 16'h0001);
        wr(16'h0001);
        chk("R2 clear enable", status_word, 16'h0000);
    endtask

    task automatic t_drain;
        wr(16'h0002);
        @(negedge clk); busy_in = 1'b1;
        wr(16'h0001);
        chk("R3 held on clear", {15'd0, run_mode}, 16'd1);
        repeat (3) @(negedge clk);
        chk("R3 held while busy", {15'd0, run_mode}, 16'd1);
        busy_in = 1'b0;
        @(negedge clk);
        chk("R3 exits after busy", {15'd0, run_mode}, 16'd0);
        wr(16'h0002);
        busy_in = 1'b1;
        wr(16'h0001);
        wr(16'h0002);
        busy_in = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3 cancel drain", {15'd0, run_mode}, 16'd1);
        wr(16'h0001);
        chk("R2 back to config", {15'd0, run_mode}, 16'd0);
    endtask

    task automatic t_master;
        wr(16'h0008);
        chk("R4 set master", status_word, 16'h0002);
        chk("R4 master port", {15'd0, master_sel}, 16'd1);
        wr(16'h0004);
        chk("R4 clear master", status_word, 16'h0000);
    endtask

    task automatic t_flags;
        for (int k = 0; k < 7; k++) begin
            wr(16'(1 << set_bit[k]));
            chk($sformatf("R5 set cell %0d", k), status_word, 16'(1 << stat_bit[k]));
            wr(16'(1 << clr_bit[k]));
            chk($sformatf("R5 clear cell %0d", k), status_word, 16'h0000);
        end
    endtask

    task automatic t_clear_all;
        wr(16'hF0AA);
        chk("R6 all set", status_word, 16'h1F83);
        wr(16'h0F50);
        chk("R6 clear errors only", status_word, 16'h0003);
        wr(16'h0005);
        chk("R6 cleanup", status_word, 16'h0000);
    endtask

    task automatic t_pairs;
        wr(16'h0003);
        chk("R7 enable pair in config", status_word, 16'h0000);
        wr(16'h1000);
        wr(16'h1100);
        chk("R7 flag pair keeps set", status_word, 16'h0100);
        wr(16'h0100);
        wr(16'h1100);
        chk("R7 flag pair keeps clear", status_word, 16'h0000);
        wr(16'h0002);
        wr(16'h0003);
        chk("R7 enable pair in run", status_word, 16'h0001);
        wr(16'h0001);
    endtask

    task automatic t_hw;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            err_chk_en = '0;
            evt_pulse = 5'(1 << k);
            @(negedge clk);
            evt_pulse = '0;
            chk($sformatf("R8 gated event %0d", k), status_word, 16'h0000);
            err_chk_en = 5'(1 << k);
            evt_pulse = 5'(1 << k);
            @(negedge clk);
            evt_pulse = '0;
            err_chk_en = '0;
            chk($sformatf("R8 enabled event %0d", k), status_word, 16'(1 << stat_bit[k]));
            wr(16'h0F50);
        end
    endtask

    task automatic t_race;
        @(negedge clk);
        err_chk_en = 5'b00001;
        evt_pulse = 5'b00001;
        cmd_we = 1'b1;
        cmd_word = 16'h0100;
        @(negedge clk);
        evt_pulse = '0;
        err_chk_en = '0;
        cmd_we = 1'b0;
        cmd_word = '0;
        chk("R9 event beats clear", status_word, 16'h0100);
        wr(16'h0100);
        chk("R9 later clear works", status_word, 16'h0000);
    endtask

    task automatic t_irq;
        wr(16'h4000);
        chk("R10 masked", {15'd0, err_irq}, 16'd0);
        irq_err_en = 1'b1;
        #1;
        chk("R10 raised", {15'd0, err_irq}, 16'd1);
        wr(16'h0400);
        chk("R10 dropped on clear", {15'd0, err_irq}, 16'd0);
        wr(16'h0080);
        chk("R10 mode error raises", {15'd0, err_irq}, 16'd1);
        wr(16'h0040);
        irq_err_en = 1'b0;
    endtask

    task automatic t_busy_ignore;
        @(negedge clk);
        busy_in = 1'b1;
        #1;
        chk("R11 busy view", status_word, 16'h2000);
        busy_in = 1'b0;
        @(negedge clk);
        cmd_we = 1'b0;
        cmd_word = 16'hFFFE;
        @(negedge clk);
        cmd_word = '0;
        chk("R11 ignored without strobe", status_word, 16'h0000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_drain();
        t_master();
        t_flags();
        t_clear_all();
        t_pairs();
        t_hw();
        t_race();
        t_irq();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule